// File: doc/BRIEF.md
# Packed-Halfword Bidirectional Shifter

This block shifts every 16-bit lane of a packed source word by one common amount. A signed 5-bit code sets both the direction and the distance. A code of zero or more shifts each lane left with zero fill. The left result is clamped to the signed 16-bit range, and an overflow flag reports the clamp. A negative code shifts each lane right arithmetically by the magnitude of the code. An optional rounding mode adds one half of the last kept bit before the lane is truncated.

A mode input selects the lane count. In wide mode all four lanes of the 64-bit word are processed. In narrow mode only the two low lanes are processed. The block takes one operation per cycle under a valid strobe and registers the result, so the result and its flag appear one clock later. Operand fetch and instruction decode belong to the surrounding pipeline and are not part of this block.

Top module: `simd_dir_shifter`

## Requirements
- R1: Only `amount[4:0]` is used. Any value on `amount[31:5]` leaves the result and the flag unchanged.
- R2: If `amount[4:0]`, read as a signed number, is 0 to 15, each active lane is shifted left by `amount[3:0]` with zero fill. When the true product fits in a signed 16-bit number, it is the lane result. Lane i occupies bits [16i+15:16i].
- R3: A left-shifted lane whose true value is above 32767 gives 0x7FFF. One below -32768 gives 0x8000. `overflow` is 1 exactly when at least one active lane was clamped.
- R4: If `amount[4:0]` is negative (bit 4 set) and rounding is off, each active lane is shifted right arithmetically by the magnitude of the code, with sign fill.
- R5: A code of -16 (0x10) gives the same result as a code of -15 (0x11).
- R6: If the code is negative with magnitude m and `round_en` is 1, each active lane gives floor((x + 2^(m-1)) / 2^m). Here x is the signed lane value.
- R7: `round_en` does not change any left-shift result. A right shift never sets `overflow`.
- R8: A code of 0 returns every active lane unchanged.
- R9: With `wide_mode` 1, all four lanes are processed. With `wide_mode` 0, lanes 0 and 1 are processed, `result[63:32]` is 0, and lanes 2 and 3 cannot set `overflow`.
- R10: `out_valid` is `in_valid` delayed by one clock. `result` and `overflow` belong to the operation accepted on that edge. `overflow` is 0 whenever `out_valid` is 0. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe for the current cycle |
| src | input | 64 | Packed source lanes, lane i at bits [16i+15:16i] |
| amount | input | 32 | Amount register value; bits [4:0] form the signed code |
| round_en | input | 1 | Rounding mode for right shifts |
| wide_mode | input | 1 | 1: four lanes, 0: two lanes |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Packed shifted lanes |
| overflow | output | 1 | At least one lane was clamped by a left shift |

## Verification
Each fault in this block shows up at the ports on the very next `out_valid` cycle, because nothing is held from one operation to the next. A wrong direction decode or a wrong magnitude for the -16 code corrupts every active lane at once. A fault in the clamp or in the rounding carry corrupts only the lanes whose values reach that path, so the stimulus puts values near the clamp limits and near odd rounding points in single lanes. A fault in the lane-enable decode shows up as nonzero upper lanes or a false `overflow` in narrow mode.

// File: rtl/simd_dir_shifter.sv
`timescale 1ns/1ps
module simd_dir_shifter #(
  parameter int XLEN        = 64,
  parameter int LANE_W      = 16,
  parameter int NARROW_XLEN = 32,
  parameter int AMT_W       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  src,
  input  logic [AMT_W-1:0] amount,
  input  logic             round_en,
  input  logic             wide_mode,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             overflow
);
  localparam int LANES        = XLEN / LANE_W;
  localparam int NARROW_LANES = NARROW_XLEN / LANE_W;
  localparam int SH_W         = $clog2(LANE_W);
  localparam int CODE_W       = SH_W + 1;
  localparam int EXT_W        = 2 * LANE_W;

  logic [CODE_W-1:0] code, neg_code;
  logic [SH_W-1:0]   lmag, rmag, rmag_m1;
  logic              go_right;
  logic              unused_amount_hi;

  assign code     = amount[CODE_W-1:0];
  assign go_right = code[CODE_W-1];
  assign neg_code = '0 - code;
  assign lmag     = code[SH_W-1:0];
  assign rmag     = neg_code[SH_W] ? '1 : neg_code[SH_W-1:0];
  assign rmag_m1  = rmag - 1'b1;
  assign unused_amount_hi = ^amount[AMT_W-1:CODE_W];

  logic [XLEN-1:0]  nxt_res;
  logic [LANES-1:0] lane_sat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [LANE_W-1:0] x, pre, trunc_val, rnd_val, left_val, lane_res;
    logic signed [EXT_W-1:0]  xe, shl;
    logic signed [LANE_W:0]   rnd_sum;
    logic                     fits, lane_on, unused_rnd_lsb;

    assign x   = src[i*LANE_W +: LANE_W];
    assign xe  = x;
    assign shl = xe <<< lmag;
    assign fits = (&shl[EXT_W-1:LANE_W-1]) | ~(|shl[EXT_W-1:LANE_W-1]);
    assign left_val = fits ? shl[LANE_W-1:0]
                    : (x[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                   : {1'b0, {(LANE_W-1){1'b1}}});

    assign trunc_val = x >>> rmag;
    assign pre       = x >>> rmag_m1;
    assign rnd_sum   = {pre[LANE_W-1], pre} + 1'b1;
    assign rnd_val   = rnd_sum[LANE_W:1];
    assign unused_rnd_lsb = rnd_sum[0];

    assign lane_res = go_right ? (round_en ? rnd_val : trunc_val) : left_val;
    assign lane_on  = wide_mode || (i < NARROW_LANES);

    assign nxt_res[i*LANE_W +: LANE_W] = lane_on ? lane_res : '0;
    assign lane_sat[i] = lane_on && !go_right && !fits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      overflow  <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      overflow  <= in_valid && (|lane_sat);
      if (in_valid) result <= nxt_res;
    end
  end
endmodule

module simd_dir_shifter_chk #(
  parameter int XLEN        = 64,
  parameter int LANE_W      = 16,
  parameter int NARROW_XLEN = 32,
  parameter int AMT_W       = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [XLEN-1:0]  src,
  input logic [AMT_W-1:0] amount,
  input logic             round_en,
  input logic             wide_mode,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic             overflow
);
  localparam int LANES  = XLEN / LANE_W;
  localparam int CODE_W = $clog2(LANE_W) + 1;

  logic [LANES-1:0] at_limit;
  for (genvar i = 0; i < LANES; i++) begin : g_lim
    assign at_limit[i] = (result[i*LANE_W +: LANE_W] == {1'b0, {(LANE_W-1){1'b1}}}) ||
                         (result[i*LANE_W +: LANE_W] == {1'b1, {(LANE_W-1){1'b0}}});
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !overflow)); // R10
  AST_RIGHT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amount[CODE_W-1]) |=> !overflow); // R7
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amount[CODE_W-1:0] == '0) |=>
      result[NARROW_XLEN-1:0] == $past(src[NARROW_XLEN-1:0])); // R8
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_mode) |=> result[XLEN-1:NARROW_XLEN] == '0); // R9
  AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (at_limit != '0)); // R3
endmodule

bind simd_dir_shifter simd_dir_shifter_chk #(
  .XLEN(XLEN), .LANE_W(LANE_W), .NARROW_XLEN(NARROW_XLEN), .AMT_W(AMT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .amount(amount),
  .round_en(round_en), .wide_mode(wide_mode), .out_valid(out_valid),
  .result(result), .overflow(overflow)
);

// File: tb/simd_dir_shifter_test.sv
`timescale 1ns/1ps
module simd_dir_shifter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src = '0;
  logic [31:0] amount = '0;
  logic        round_en = 1'b0;
  logic        wide_mode = 1'b1;
  logic        out_valid;
  logic [63:0] result;
  logic        overflow;

  int compared = 0;
  int mismatched = 0;

  logic [63:0] q_res[$];
  logic        q_ovf[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  simd_dir_shifter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .amount(amount),
    .round_en(round_en), .wide_mode(wide_mode), .out_valid(out_valid),
    .result(result), .overflow(overflow)
  );

  function automatic void model(input logic [63:0] s, input logic [31:0] a,
                                input logic rnd, input logic wide,
                                output logic [63:0] r, output logic ov);
    int sv, m, lanes;
    longint x, v;
    r = '0; ov = 1'b0;
    sv = a[4] ? int'(a[4:0]) - 32 : int'(a[4:0]);
    lanes = wide ? 4 : 2;
    for (int l = 0; l < lanes; l++) begin
      x = longint'($signed(s[16*l +: 16]));
      if (sv >= 0) begin
        v = x * (longint'(1) << sv);
        if (v > 32767) begin v = 32767; ov = 1'b1; end
        else if (v < -32768) begin v = -32768; ov = 1'b1; end
      end else begin
        m = -sv;
        if (m == 16) m = 15;
        if (rnd) v = (x + (longint'(1) << (m - 1))) >>> m;
        else     v = x >>> m;
      end
      r[16*l +: 16] = v[15:0];
    end
  endfunction

  function automatic string classify(input logic [31:0] a, input logic [63:0] r_ov_dummy,
                                     input logic rnd, input logic ov);
    if (r_ov_dummy == 64'h1) return "R2";
    if (a[4:0] == 5'd0) return "R8";
    if (a[4]) return rnd ? "R6" : "R4";
    return ov ? "R3" : "R2";
  endfunction

  task automatic send(input logic [63:0] s, input logic [31:0] a, input logic rnd,
                      input logic wide, input string tag);
    logic [63:0] r;
    logic ov;
    model(s, a, rnd, wide, r, ov);
    @(negedge clk);
    src = s; amount = a; round_en = rnd; wide_mode = wide; in_valid = 1'b1;
    q_res.push_back(r);
    q_ovf.push_back(ov);
    q_tag.push_back(tag == "" ? classify(a, 64'h0, rnd, ov) : tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q_res.size() == 0) begin
          mismatched++;
          $display("FAIL R10: out_valid with no pending item, actual 1 expected 0");
        end else begin
          logic [63:0] er;
          logic eo;
          string t;
          er = q_res.pop_front(); eo = q_ovf.pop_front(); t = q_tag.pop_front();
          compared++;
          if (result !== er || overflow !== eo) begin
            mismatched++;
            $display("FAIL %s: actual result=%h ovf=%b expected result=%h ovf=%b",
                     t, result, overflow, er, eo);
          end
        end
      end else if (overflow !== 1'b0) begin
        mismatched++;
        $display("FAIL R10: overflow while idle, actual %b expected 0", overflow);
      end
    end
  end

  initial begin
    repeat (2000000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    compared++;
    if (out_valid !== 1'b0 || result !== 64'h0 || overflow !== 1'b0) begin
      mismatched++;
      $display("FAIL R10: reset outputs actual %b/%h/%b expected 0/0/0",
               out_valid, result, overflow);
    end
    rst = 1'b0;

    // R2 plain left shifts, R3 clamping in single lanes
    send(64'h0001_0002_FFFF_0100, 32'h3, 1'b0, 1'b1, "R2");
    send(64'h0001_0002_4000_0003, 32'h1, 1'b0, 1'b1, "R3");
    send(64'hC000_0001_0001_0001, 32'h2, 1'b0, 1'b1, "R3");
    send(64'h0001_0001_0001_0001, 32'hF, 1'b0, 1'b1, "R3");
    // R4 arithmetic right, R5 -16 equals -15
    send(64'h8000_7FF0_FFF1_0010, 32'h1C, 1'b0, 1'b1, "R4");
    send(64'h8000_7FFF_1234_FEDC, 32'h10, 1'b0, 1'b1, "R5");
    send(64'h8000_7FFF_1234_FEDC, 32'h11, 1'b0, 1'b1, "R5");
    send(64'h8000_7FFF_1234_FEDC, 32'h10, 1'b1, 1'b1, "R5");
    // R6 rounding at odd points and extremes
    send(64'h0003_FFFD_7FFF_8000, 32'h1F, 1'b1, 1'b1, "R6");
    send(64'h0018_FFE8_0017_FFE7, 32'h1D, 1'b1, 1'b1, "R6");
    idle(2);
    // R7 rounding flag ignored on left shifts
    send(64'h4000_0001_C000_0005, 32'h2, 1'b1, 1'b1, "R7");
    send(64'h7FFF_8000_0001_0002, 32'h1F, 1'b1, 1'b1, "R7");
    // R8 zero code, R1 upper amount bits ignored
    send(64'h8000_7FFF_ABCD_1234, 32'h0, 1'b1, 1'b1, "R8");
    send(64'h8000_7FFF_ABCD_1234, 32'h1234_5660, 1'b0, 1'b1, "R1");
    send(64'h0001_0002_FFFF_0100, 32'hFFFF_FFE3, 1'b0, 1'b1, "R1");
    // R9 narrow mode: upper lanes dropped and cannot flag overflow
    send(64'h7FFF_4000_0001_0002, 32'h4, 1'b0, 1'b0, "R9");
    send(64'h8000_C000_FFF0_0010, 32'h1E, 1'b1, 1'b0, "R9");
    send(64'h7FFF_7FFF_4000_0001, 32'h1, 1'b0, 1'b0, "R9");
    idle(3);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] s;
      s = {$urandom(), $urandom()};
      if (n % 7 == 0) s[15:0] = 16'h7FFF;
      send(s, $urandom(), 1'($urandom()), 1'($urandom()), "");
      if (n % 11 == 0) idle(1);
    end
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule